// File: doc/BRIEF.md
# Banked Register File with Shadow Pairs

This block is the register storage of a small 8-bit processor core. It holds four byte-wide working registers, A, B, X and Y. A and B together form the 16-bit pair AB, and Y and X together form the pair YX. A 16-bit frame register DP sits beside them. Each of the three 16-bit values AB, YX and DP has a hidden shadow copy of the same width. The shadow copies can be reached only by swapping them with their working value.

The datapath reads any two byte registers at once through two combinational read ports. It writes one byte per clock, or it writes a whole pair at once, for example a multiply product into AB or a return address into YX. A command input asks for one single-cycle operation: swap a pair with its shadow, exchange YX with DP, or step DP up or down. The processor flag does not gate the DP step. Only one action takes effect on each clock. The command wins over a pair write, and a pair write wins over a byte write.

Top module: `bank_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears A, B, X, Y, DP and all three shadow copies to zero, so a swap issued right after reset brings zero into the working value.
- R2: A byte write (wr_en) stores wr_data into the register selected by wr_sel, with the encoding 0=A, 1=B, 2=X, 3=Y. Read ports 0 and 1 return the current register named by their own select, using the same encoding.
- R3: The pair outputs are ab_out = {A,B} and yx_out = {Y,X}, with A and Y as the high bytes. A pair write (pair_wr_en) loads pair_wr_data into AB when pair_wr_sel=0 and into YX when pair_wr_sel=1.
- R4: Commands 1, 2 and 3 exchange AB, YX and DP respectively with their own shadow copy in one clock.
- R5: Command 4 exchanges the full 16-bit YX value with DP in one clock.
- R6: Command 5 increments DP and command 6 decrements DP, both modulo 65536 (FFFF+1=0000, 0000-1=FFFF).
- R7: Only one action takes effect per clock. Commands 1 to 6 take priority over a pair write, and a pair write takes priority over a byte write. The losing requests leave no trace.
- R8: With command 0 or 7 and no write, every register holds its value. Byte and pair writes never alter a shadow copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_sel | input | 2 | Read port 0 register select |
| rd0_data | output | 8 | Read port 0 data |
| rd1_sel | input | 2 | Read port 1 register select |
| rd1_data | output | 8 | Read port 1 data |
| wr_en | input | 1 | Byte write request |
| wr_sel | input | 2 | Byte write register select |
| wr_data | input | 8 | Byte write data |
| pair_wr_en | input | 1 | Pair write request |
| pair_wr_sel | input | 1 | Pair write target, 0=AB, 1=YX |
| pair_wr_data | input | 16 | Pair write data |
| cmd | input | 3 | Command: 0 none, 1 swap AB, 2 swap YX, 3 swap DP, 4 exchange YX/DP, 5 DP+1, 6 DP-1, 7 none |
| ab_out | output | 16 | Current AB value |
| yx_out | output | 16 | Current YX value |
| dp_out | output | 16 | Current DP value |

## Verification
The shadow copies have no port of their own. Their contents can only be inferred from what a later swap brings into the working value. The stimulus therefore writes a pair, swaps it away, overwrites the working copy with a different value, and swaps back to show that the shadow kept its value. The DP wrap case is reached by loading FFFF into YX and exchanging it into DP before stepping. A long random phase raises several requests in the same clock so that the priority order is exercised against the reference model on every edge.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_SWAP_AB = 3'd1,
    CMD_SWAP_YX = 3'd2,
    CMD_SWAP_DP = 3'd3,
    CMD_XCHG    = 3'd4,
    CMD_DP_UP   = 3'd5,
    CMD_DP_DOWN = 3'd6,
    CMD_SPARE   = 3'd7
  } rf_cmd_e;

  // Register select encoding shared by the read and write ports
  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_X = 2'd2;
  localparam logic [1:0] SEL_Y = 2'd3;

  // True when the selected byte is the upper half of its pair
  function automatic logic sel_is_high(input logic [1:0] sel);
    return (sel == SEL_A) || (sel == SEL_Y);
  endfunction

endpackage

// File: rtl/rf_arbiter.sv
module rf_arbiter
  import bank_regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cmd,
  input  logic       pair_req,
  input  logic       byte_req,
  output logic       ev_swap_ab,
  output logic       ev_swap_yx,
  output logic       ev_swap_dp,
  output logic       ev_xchg,
  output logic       ev_dp_up,
  output logic       ev_dp_down,
  output logic       ev_pair_wr,
  output logic       ev_byte_wr
);

  logic cmd_live;

  always_comb begin
    ev_swap_ab = 1'b0;
    ev_swap_yx = 1'b0;
    ev_swap_dp = 1'b0;
    ev_xchg    = 1'b0;
    ev_dp_up   = 1'b0;
    ev_dp_down = 1'b0;
    cmd_live   = 1'b1;
    case (rf_cmd_e'(cmd))
      CMD_SWAP_AB: ev_swap_ab = 1'b1;
      CMD_SWAP_YX: ev_swap_yx = 1'b1;
      CMD_SWAP_DP: ev_swap_dp = 1'b1;
      CMD_XCHG:    ev_xchg    = 1'b1;
      CMD_DP_UP:   ev_dp_up   = 1'b1;
      CMD_DP_DOWN: ev_dp_down = 1'b1;
      default:     cmd_live   = 1'b0;
    endcase
    ev_pair_wr = pair_req && !cmd_live;
    ev_byte_wr = byte_req && !cmd_live && !pair_req;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_swap_ab, ev_swap_yx, ev_swap_dp, ev_xchg,
              ev_dp_up, ev_dp_down, ev_pair_wr, ev_byte_wr})); // R7

endmodule

// File: rtl/rf_pair_bank.sv
module rf_pair_bank #(
  parameter int BW = 8,
  localparam int PW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap,
  input  logic          load_we,
  input  logic [PW-1:0] load_data,
  input  logic          word_we,
  input  logic [PW-1:0] word_data,
  input  logic          byte_we,
  input  logic          byte_hi,
  input  logic [BW-1:0] byte_data,
  output logic [PW-1:0] work_q
);

  logic [PW-1:0] shadow_q;
  logic          any_write;

  assign any_write = swap || load_we || word_we || byte_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q   <= '0;
      shadow_q <= '0;
    end else if (swap) begin
      work_q   <= shadow_q;
      shadow_q <= work_q;
    end else if (load_we) begin
      work_q <= load_data;
    end else if (word_we) begin
      work_q <= word_data;
    end else if (byte_we) begin
      if (byte_hi) work_q[PW-1:BW] <= byte_data;
      else         work_q[BW-1:0]  <= byte_data;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (work_q == '0) && (shadow_q == '0)); // R1
  AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (rst)
    swap |=> (work_q == $past(shadow_q)) && (shadow_q == $past(work_q))); // R4
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
    !swap |=> $stable(shadow_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !any_write |=> $stable(work_q)); // R8

endmodule

// File: rtl/rf_frame_reg.sv
module rf_frame_reg #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap,
  input  logic          load_we,
  input  logic [PW-1:0] load_data,
  input  logic          step_up,
  input  logic          step_down,
  output logic [PW-1:0] dp_q
);

  logic [PW-1:0] shadow_q;

  // Wrapping one-step move of the frame value
  function automatic logic [PW-1:0] frame_step(input logic [PW-1:0] v,
                                               input logic down);
    return down ? v - PW'(1) : v + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_q     <= '0;
      shadow_q <= '0;
    end else if (swap) begin
      dp_q     <= shadow_q;
      shadow_q <= dp_q;
    end else if (load_we) begin
      dp_q <= load_data;
    end else if (step_up || step_down) begin
      dp_q <= frame_step(dp_q, step_down);
    end
  end

  AST_DP_RESET: assert property (@(posedge clk)
    rst |=> (dp_q == '0) && (shadow_q == '0)); // R1
  AST_DP_SWAP: assert property (@(posedge clk) disable iff (rst)
    swap |=> (dp_q == $past(shadow_q)) && (shadow_q == $past(dp_q))); // R4
  AST_DP_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (step_up && !swap && !load_we && (dp_q == '1)) |=> (dp_q == '0)); // R6
  AST_DP_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (step_down && !swap && !load_we && (dp_q == '0)) |=> (dp_q == '1)); // R6

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int BW = 8,
  localparam int PW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    rd0_sel,
  output logic [BW-1:0] rd0_data,
  input  logic [1:0]    rd1_sel,
  output logic [BW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [BW-1:0] wr_data,
  input  logic          pair_wr_en,
  input  logic          pair_wr_sel,
  input  logic [PW-1:0] pair_wr_data,
  input  logic [2:0]    cmd,
  output logic [PW-1:0] ab_out,
  output logic [PW-1:0] yx_out,
  output logic [PW-1:0] dp_out
);

  logic ev_swap_ab, ev_swap_yx, ev_swap_dp, ev_xchg;
  logic ev_dp_up, ev_dp_down, ev_pair_wr, ev_byte_wr;
  logic [PW-1:0] pair_q [2];
  logic [1:0]    swap_vec;
  logic          byte_hi;

  rf_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .pair_req   (pair_wr_en),
    .byte_req   (wr_en),
    .ev_swap_ab (ev_swap_ab),
    .ev_swap_yx (ev_swap_yx),
    .ev_swap_dp (ev_swap_dp),
    .ev_xchg    (ev_xchg),
    .ev_dp_up   (ev_dp_up),
    .ev_dp_down (ev_dp_down),
    .ev_pair_wr (ev_pair_wr),
    .ev_byte_wr (ev_byte_wr)
  );

  assign swap_vec = {ev_swap_yx, ev_swap_ab};
  assign byte_hi  = sel_is_high(wr_sel);

  // Bank 0 is AB, bank 1 is YX; bit 1 of the byte select picks the bank
  for (genvar g = 0; g < 2; g++) begin : g_pair
    rf_pair_bank #(.BW(BW)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .swap      (swap_vec[g]),
      .load_we   ((g == 1) ? ev_xchg : 1'b0),
      .load_data (dp_out),
      .word_we   (ev_pair_wr && (pair_wr_sel == 1'(g))),
      .word_data (pair_wr_data),
      .byte_we   (ev_byte_wr && (wr_sel[1] == 1'(g))),
      .byte_hi   (byte_hi),
      .byte_data (wr_data),
      .work_q    (pair_q[g])
    );
  end

  rf_frame_reg #(.PW(PW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .swap      (ev_swap_dp),
    .load_we   (ev_xchg),
    .load_data (pair_q[1]),
    .step_up   (ev_dp_up),
    .step_down (ev_dp_down),
    .dp_q      (dp_out)
  );

  assign ab_out = pair_q[0];
  assign yx_out = pair_q[1];

  function automatic logic [BW-1:0] pick(input logic [1:0] sel,
                                         input logic [PW-1:0] ab,
                                         input logic [PW-1:0] yx);
    case (sel)
      SEL_A:   return ab[PW-1:BW];
      SEL_B:   return ab[BW-1:0];
      SEL_X:   return yx[BW-1:0];
      default: return yx[PW-1:BW];
    endcase
  endfunction

  assign rd0_data = pick(rd0_sel, pair_q[0], pair_q[1]);
  assign rd1_data = pick(rd1_sel, pair_q[0], pair_q[1]);

  AST_XCHG_BOTH: assert property (@(posedge clk) disable iff (rst)
    ev_xchg |=> (yx_out == $past(dp_out)) && (dp_out == $past(yx_out))); // R5
  AST_CMD_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (ev_swap_dp || ev_dp_up || ev_dp_down) |=> $stable(ab_out) && $stable(yx_out)); // R7

endmodule

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
  logic [7:0]  rd0_data, rd1_data, wr_data = '0;
  logic        wr_en = 1'b0, pair_wr_en = 1'b0, pair_wr_sel = 1'b0;
  logic [15:0] pair_wr_data = '0;
  logic [2:0]  cmd = '0;
  logic [15:0] ab_out, yx_out, dp_out;

  int vectors = 0;
  int miscompares = 0;

  // Reference state
  logic [15:0] m_ab = '0, m_yx = '0, m_dp = '0;
  logic [15:0] s_ab = '0, s_yx = '0, s_dp = '0;

  always #4 clk = ~clk;

  bank_regfile dut_i (
    .clk(clk), .rst(rst),
    .rd0_sel(rd0_sel), .rd0_data(rd0_data),
    .rd1_sel(rd1_sel), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pair_wr_en(pair_wr_en), .pair_wr_sel(pair_wr_sel), .pair_wr_data(pair_wr_data),
    .cmd(cmd), .ab_out(ab_out), .yx_out(yx_out), .dp_out(dp_out)
  );

  function automatic logic [7:0] ref_byte(input logic [1:0] s);
    case (s)
      2'd0: return m_ab[15:8];
      2'd1: return m_ab[7:0];
      2'd2: return m_yx[7:0];
      default: return m_yx[15:8];
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [7:0] e0, e1;
    e0 = ref_byte(rd0_sel);
    e1 = ref_byte(rd1_sel);
    vectors++;
    if (rd0_data !== e0 || rd1_data !== e1 || ab_out !== m_ab ||
        yx_out !== m_yx || dp_out !== m_dp) begin
      miscompares++;
      $display("FAIL %s: rd0=%h rd1=%h ab=%h yx=%h dp=%h expected rd0=%h rd1=%h ab=%h yx=%h dp=%h",
               tag, rd0_data, rd1_data, ab_out, yx_out, dp_out, e0, e1, m_ab, m_yx, m_dp);
    end
  endtask

  // Reference next state, written from the requirements
  task automatic model_step();
    logic [15:0] t;
    if (rst) begin
      m_ab = 0; m_yx = 0; m_dp = 0; s_ab = 0; s_yx = 0; s_dp = 0;
    end else if (cmd >= 3'd1 && cmd <= 3'd6) begin
      case (cmd)
        3'd1: begin t = m_ab; m_ab = s_ab; s_ab = t; end
        3'd2: begin t = m_yx; m_yx = s_yx; s_yx = t; end
        3'd3: begin t = m_dp; m_dp = s_dp; s_dp = t; end
        3'd4: begin t = m_yx; m_yx = m_dp; m_dp = t; end
        3'd5: m_dp = 16'((int'(m_dp) + 1) % 65536);
        default: m_dp = 16'((int'(m_dp) + 65535) % 65536);
      endcase
    end else if (pair_wr_en) begin
      if (pair_wr_sel) m_yx = pair_wr_data; else m_ab = pair_wr_data;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: m_ab[15:8] = wr_data;
        2'd1: m_ab[7:0]  = wr_data;
        2'd2: m_yx[7:0]  = wr_data;
        default: m_yx[15:8] = wr_data;
      endcase
    end
  endtask

  task automatic apply(input logic r, input logic [2:0] c,
                       input logic pwe, input logic psel, input logic [15:0] pd,
                       input logic bwe, input logic [1:0] bs, input logic [7:0] bd,
                       input logic [1:0] s0, input logic [1:0] s1, input string tag);
    rst = r; cmd = c; pair_wr_en = pwe; pair_wr_sel = psel; pair_wr_data = pd;
    wr_en = bwe; wr_sel = bs; wr_data = bd; rd0_sel = s0; rd1_sel = s1;
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  function automatic string tag_for(input logic [2:0] c, input logic pwe, input logic bwe);
    if (c >= 3'd1 && c <= 3'd6 && (pwe || bwe)) return "R7";
    if (c >= 3'd1 && c <= 3'd3) return "R4";
    if (c == 3'd4) return "R5";
    if (c == 3'd5 || c == 3'd6) return "R6";
    if (pwe && bwe) return "R7";
    if (pwe) return "R3";
    if (bwe) return "R2";
    return "R8";
  endfunction

  initial begin
    #(8 * 100000);
    miscompares++;
    $display("FAIL watchdog: expired, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset clears, shadows proven zero by swapping after dirtying
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    apply(0, 0, 1, 0, 16'h1234, 0, 0, 0, 0, 1, "R3");
    apply(0, 0, 1, 1, 16'h5678, 0, 0, 0, 2, 3, "R3");
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    apply(0, 2, 0, 0, 0, 0, 0, 0, 2, 3, "R1");
    apply(0, 3, 0, 0, 0, 0, 0, 0, 0, 1, "R1");
    // R2: byte writes into every register, read back on both ports
    apply(0, 0, 0, 0, 0, 1, 0, 8'hA1, 0, 1, "R2");
    apply(0, 0, 0, 0, 0, 1, 1, 8'hB2, 0, 1, "R2");
    apply(0, 0, 0, 0, 0, 1, 2, 8'hC3, 2, 3, "R2");
    apply(0, 0, 0, 0, 0, 1, 3, 8'hD4, 3, 2, "R2");
    // R4 and R8: shadow survives an overwrite of the working pair
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
    apply(0, 0, 1, 0, 16'hBEEF, 0, 0, 0, 0, 1, "R3");
    apply(0, 0, 0, 0, 0, 1, 1, 8'h77, 0, 1, "R8");
    apply(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
    apply(0, 2, 0, 0, 0, 0, 0, 0, 3, 2, "R4");
    apply(0, 2, 0, 0, 0, 0, 0, 0, 3, 2, "R4");
    // R5 and R6: load FFFF into DP via exchange, then wrap both ways
    apply(0, 0, 1, 1, 16'hFFFF, 0, 0, 0, 3, 2, "R3");
    apply(0, 4, 0, 0, 0, 0, 0, 0, 3, 2, "R5");
    apply(0, 5, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
    apply(0, 6, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
    apply(0, 6, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
    apply(0, 3, 0, 0, 0, 0, 0, 0, 0, 1, "R4");
    apply(0, 4, 0, 0, 0, 0, 0, 0, 3, 2, "R5");
    // R7: priorities
    apply(0, 1, 1, 0, 16'h0F0F, 1, 0, 8'h55, 0, 1, "R7");
    apply(0, 0, 1, 1, 16'hCAFE, 1, 2, 8'h99, 2, 3, "R7");
    apply(0, 5, 1, 1, 16'h1111, 1, 3, 8'h22, 3, 2, "R7");
    // R8: idle codes hold everything
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 3, "R8");
    apply(0, 7, 0, 0, 0, 0, 0, 0, 1, 2, "R8");
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] c;
      logic pwe, bwe;
      c   = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
      pwe = ($urandom_range(0, 3) == 0);
      bwe = ($urandom_range(0, 1) == 0);
      apply(($urandom_range(0, 199) == 0), c, pwe, 1'($urandom_range(0, 1)),
            16'($urandom), bwe, 2'($urandom_range(0, 3)), 8'($urandom),
            2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            tag_for(c, pwe, bwe));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule